// File: doc/BRIEF.md
# Level Interrupt Line Mapper

This block collects single-cycle event pulses from several groups of event sources (queue, timer, I/O controller and composite events) into sticky status registers, and drives three interrupt output lines towards a host processor. Each event has a software-written route field that sends it to one of the three lines or switches it off. Each line is the level OR of all pending events routed to it. A line therefore stays high until software has cleared every pending source that drives it.

Software reaches the block through a simple register port. There are two kinds of register. The status registers record events, and software clears their bits by writing ones to them. The route registers hold two bits per event. The three lines are usually labelled low, medium and high, but the hardware gives none of them precedence. Only the route fields decide which events reach which line. Any combination of lines may be high at the same time.

Top module: `irq_line_mapper`

## Requirements
- R1: After a synchronous active-low reset, all status registers read 0x0000, all route registers read 0xFFFF (every event disabled), and `irq_o` is 3'b000.
- R2: A 1 on `evt_i[e]` for one cycle sets a sticky status bit. The bit stays set until software clears it. Event e = 8*g + b appears at bit b of the status register at address g (g = 0..3).
- R3: A write to status address g clears each status bit whose `wr_data_i` bit is 1 and leaves alone each bit whose data bit is 0. Data bits 15:8 are ignored.
- R4: If an event pulse and a clear of the same status bit arrive in the same cycle, the event wins and the bit reads 1 afterwards.
- R5: The route register at address 4+g holds bits [2b+1:2b] for event 8*g+b. Codes 0, 1 and 2 send the event to `irq_o[0]`, `irq_o[1]` and `irq_o[2]`. Code 3 disables the event for the lines, but the event is still recorded in its status bit.
- R6: Each line is high exactly when at least one pending status bit is routed to it. With several such events pending, the line stays high until the last of them is cleared.
- R7: `irq_o` is registered. It reflects the status and route registers as they stood one clock earlier, so it changes one cycle after a status or route register changes.
- R8: No line has priority over another. Events routed to different lines raise all of those lines at once. Rerouting a pending event moves it to the new line, or drops it, one cycle after the route write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 32 | Event pulses, one bit per event |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address (0-3 status, 4-7 route) |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 16 | Register read data, combinational from rd_addr_i |
| irq_o | output | 3 | Interrupt lines, active high |

## Verification
Two situations are hardest to reach from the ports. One is the collision between an event pulse and a write-one clear of the same bit. The bench drives both in the same cycle and then reads the status bit back. The other is a line shared by events from two different groups. The bench routes both events to one line, sets both, and clears them one at a time, checking after each clear that the line stays up until the last source is gone. Rerouting a pending event to the disabled code shows whether a line drops while its status is kept.

// File: rtl/irq_map_pkg.sv
// Package: shared constants and route codes for the interrupt line mapper.
// Assumes exactly three output lines; the route code field is two bits wide.
package irq_map_pkg;
    localparam int NUM_LINES = 3;
    localparam int ROUTE_W   = 2;

    typedef enum logic [ROUTE_W-1:0] {
        ROUTE_L0  = 2'd0,
        ROUTE_L1  = 2'd1,
        ROUTE_L2  = 2'd2,
        ROUTE_OFF = 2'd3
    } route_e;
endpackage

// File: rtl/irq_status_bank.sv
// Module: sticky status registers, one per event group.
// Event pulses set bits; a write of ones to the group's address clears bits.
// A set in the same cycle as a clear wins. Assumes DATA_W >= GRP_W.
module irq_status_bank #(
    parameter int NUM_GROUPS = 4,
    parameter int GRP_W      = 8,
    parameter int ADDR_W     = 3,
    parameter int DATA_W     = 16,
    localparam int N_EVT     = NUM_GROUPS * GRP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_EVT-1:0]  evt_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [N_EVT-1:0]  status_o
);
    logic [N_EVT-1:0] clr_vec;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        // Decode the clear mask for this group from the register port.
        always_comb begin
            clr_vec[g*GRP_W +: GRP_W] = '0;
            if (wr_en_i && (wr_addr_i == ADDR_W'(g)))
                clr_vec[g*GRP_W +: GRP_W] = wr_data_i[GRP_W-1:0];
        end

        // Hold sticky bits: clear requested ones, then let events set them.
        always_ff @(posedge clk) begin
            if (!rst_n)
                status_o[g*GRP_W +: GRP_W] <= '0;
            else
                status_o[g*GRP_W +: GRP_W] <= (status_o[g*GRP_W +: GRP_W]
                                              & ~clr_vec[g*GRP_W +: GRP_W])
                                             | evt_i[g*GRP_W +: GRP_W];
        end
    end

    // R2 / R4: an event pulse always leaves its bit set, even against a clear.
    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((status_o & $past(evt_i)) == $past(evt_i)));

    // R3: a cleared bit without a same-cycle event reads 0.
    a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_vec & ~evt_i) != '0) |=> ((status_o & $past(clr_vec & ~evt_i)) == '0));

    // R2: bits neither set nor cleared keep their value.
    a_r2_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n)) |-> ((status_o & ~$past(clr_vec | evt_i))
                            == ($past(status_o) & ~$past(clr_vec | evt_i))));
endmodule

// File: rtl/irq_route_regs.sv
// Module: per-event route fields, one DATA_W register per event group.
// Register for group g sits at address NUM_GROUPS+g. Resets to all ones
// (every event disabled). Assumes DATA_W == GRP_W * ROUTE_W.
module irq_route_regs
    import irq_map_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    parameter int GRP_W      = 8,
    parameter int ADDR_W     = 3,
    parameter int DATA_W     = 16,
    localparam int N_EVT     = NUM_GROUPS * GRP_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en_i,
    input  logic [ADDR_W-1:0]         wr_addr_i,
    input  logic [DATA_W-1:0]         wr_data_i,
    output logic [N_EVT*ROUTE_W-1:0]  route_o
);
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        // Load the group's route register on a write to its address.
        always_ff @(posedge clk) begin
            if (!rst_n)
                route_o[g*DATA_W +: DATA_W] <= '1;
            else if (wr_en_i && (wr_addr_i == ADDR_W'(NUM_GROUPS + g)))
                route_o[g*DATA_W +: DATA_W] <= wr_data_i;
        end
    end

    // R1: route fields start disabled after reset.
    a_r1_route_reset: assert property (@(posedge clk)
        (!rst_n) |=> (route_o == '1));
endmodule

// File: rtl/irq_line_gen.sv
// Module: builds each interrupt line as the OR of pending events routed to it,
// registered so the outputs are glitch-free and low during reset.
// Assumes route code 3 means disabled and codes 0..2 name a line.
module irq_line_gen
    import irq_map_pkg::*;
#(
    parameter int N_EVT = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_EVT-1:0]          status_i,
    input  logic [N_EVT*ROUTE_W-1:0]  route_i,
    output logic [NUM_LINES-1:0]      irq_o
);
    logic [NUM_LINES-1:0] hit;

    // Gather, per line, whether any pending event is routed there.
    always_comb begin
        hit = '0;
        for (int e = 0; e < N_EVT; e++) begin
            for (int l = 0; l < NUM_LINES; l++) begin
                if (status_i[e] && (route_i[e*ROUTE_W +: ROUTE_W] == ROUTE_W'(l)))
                    hit[l] = 1'b1;
            end
        end
    end

    // Register the line levels.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_o <= '0;
        else
            irq_o <= hit;
    end

    // R1 / R7: lines are low in the cycle after reset is sampled.
    a_r7_reset_low: assert property (@(posedge clk)
        (!rst_n) |=> (irq_o == '0));

    // R6: nothing pending means every line drops on the next cycle.
    a_r6_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (status_i == '0) |=> (irq_o == '0));

    // R5: with every event disabled no line can rise.
    a_r5_all_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        (&route_i) |=> (irq_o == '0));
endmodule

// File: rtl/irq_line_mapper.sv
// Module: top of the interrupt line mapper. Holds sticky status registers,
// per-event route registers and three registered level interrupt lines,
// and exposes a simple register port (addresses 0..NUM_GROUPS-1 status,
// NUM_GROUPS..2*NUM_GROUPS-1 route). Reads are combinational.
module irq_line_mapper
    import irq_map_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    parameter int GRP_W      = 8,
    localparam int N_EVT     = NUM_GROUPS * GRP_W,
    localparam int DATA_W    = GRP_W * ROUTE_W,
    localparam int ADDR_W    = $clog2(2 * NUM_GROUPS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_EVT-1:0]     evt_i,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    wr_addr_i,
    input  logic [DATA_W-1:0]    wr_data_i,
    input  logic [ADDR_W-1:0]    rd_addr_i,
    output logic [DATA_W-1:0]    rd_data_o,
    output logic [NUM_LINES-1:0] irq_o
);
    logic [N_EVT-1:0]         status;
    logic [N_EVT*ROUTE_W-1:0] route;

    irq_status_bank #(
        .NUM_GROUPS(NUM_GROUPS), .GRP_W(GRP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) status_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .status_o(status)
    );

    irq_route_regs #(
        .NUM_GROUPS(NUM_GROUPS), .GRP_W(GRP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) route_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .route_o(route)
    );

    irq_line_gen #(.N_EVT(N_EVT)) lines_i (
        .clk(clk), .rst_n(rst_n),
        .status_i(status), .route_i(route),
        .irq_o(irq_o)
    );

    // Select read data: zero-extended status or a full route register.
    always_comb begin
        rd_data_o = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (rd_addr_i == ADDR_W'(g))
                rd_data_o = DATA_W'(status[g*GRP_W +: GRP_W]);
            if (rd_addr_i == ADDR_W'(NUM_GROUPS + g))
                rd_data_o = route[g*DATA_W +: DATA_W];
        end
    end

    // R1: status registers are empty after reset.
    a_r1_status_reset: assert property (@(posedge clk)
        (!rst_n) |=> (status == '0));

    // R6: a high line always has a pending event behind it one cycle earlier.
    a_r6_line_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o != '0) |-> ($past(status) != '0));
endmodule

// File: tb/irq_line_mapper_tb_top.sv
`timescale 1ns/1ps
module irq_line_mapper_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [2:0]  irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_line_mapper dut_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_wr(logic [2:0] a, logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc(1);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic reg_rd(logic [2:0] a, output logic [15:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        check("R1", "irq after reset", 32'(irq), 32'h0);
        for (int g = 0; g < 4; g++) begin
            reg_rd(3'(g), d);
            check("R1", "status after reset", 32'(d), 32'h0);
            reg_rd(3'(4 + g), d);
            check("R1", "route after reset", 32'(d), 32'hFFFF);
        end
    endtask

    task automatic t_sticky();
        logic [15:0] d;
        evt[5] = 1'b1; cyc(1); evt = '0;
        reg_rd(3'd0, d);
        check("R2", "status set by pulse", 32'(d), 32'h20);
        cyc(5);
        reg_rd(3'd0, d);
        check("R2", "status still held", 32'(d), 32'h20);
        check("R5", "disabled event keeps lines low", 32'(irq), 32'h0);
    endtask

    task automatic t_route();
        logic [15:0] d;
        reg_wr(3'd4, 16'hF7FF);
        check("R7", "line not yet up one cycle early", 32'(irq), 32'h0);
        cyc(1);
        check("R5", "event 5 on line 1", 32'(irq), 32'h2);
        reg_rd(3'd4, d);
        check("R5", "route readback", 32'(d), 32'hF7FF);
    endtask

    task automatic t_w1c();
        logic [15:0] d;
        reg_wr(3'd0, 16'h0000); cyc(1);
        reg_rd(3'd0, d);
        check("R3", "write zero leaves bit", 32'(d), 32'h20);
        check("R3", "line kept after zero write", 32'(irq), 32'h2);
        reg_wr(3'd0, 16'hFF00); cyc(1);
        reg_rd(3'd0, d);
        check("R3", "upper data bits ignored", 32'(d), 32'h20);
        reg_wr(3'd0, 16'h0020);
        reg_rd(3'd0, d);
        check("R3", "write one clears", 32'(d), 32'h0);
        check("R7", "line lags clear by a cycle", 32'(irq), 32'h2);
        cyc(1);
        check("R6", "line drops after clear", 32'(irq), 32'h0);
    endtask

    task automatic t_shared();
        reg_wr(3'd5, 16'hFFFE);
        reg_wr(3'd6, 16'hFFFB);
        evt[8] = 1'b1; evt[17] = 1'b1; cyc(1); evt = '0;
        cyc(1);
        check("R6", "shared line up", 32'(irq), 32'h4);
        reg_wr(3'd1, 16'h0001); cyc(1);
        check("R6", "line held by second source", 32'(irq), 32'h4);
        reg_wr(3'd2, 16'h0002); cyc(1);
        check("R6", "line drops after last clear", 32'(irq), 32'h0);
    endtask

    task automatic t_race();
        logic [15:0] d;
        evt[8] = 1'b1;
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = 16'h0001;
        cyc(1);
        evt = '0; wr_en = 1'b0; wr_data = '0;
        reg_rd(3'd1, d);
        check("R4", "event wins over clear", 32'(d), 32'h1);
        cyc(1);
        check("R4", "line from colliding event", 32'(irq), 32'h4);
        reg_wr(3'd1, 16'h0001); cyc(1);
        check("R4", "line low after later clear", 32'(irq), 32'h0);
    endtask

    task automatic t_no_priority();
        logic [15:0] d;
        reg_wr(3'd7, 16'h3FFF);
        evt[5] = 1'b1; evt[8] = 1'b1; evt[31] = 1'b1; cyc(1); evt = '0;
        cyc(1);
        check("R8", "all three lines together", 32'(irq), 32'h7);
        reg_wr(3'd5, 16'hFFFF); cyc(1);
        check("R8", "reroute to off drops line 2", 32'(irq), 32'h3);
        reg_rd(3'd1, d);
        check("R5", "disabled event still recorded", 32'(d), 32'h1);
        reg_wr(3'd5, 16'hFFFD); cyc(1);
        check("R8", "reroute moves event to line 1", 32'(irq), 32'h3);
        reg_wr(3'd0, 16'h00FF); cyc(1);
        check("R8", "line 1 held by moved event", 32'(irq), 32'h3);
        reg_wr(3'd1, 16'h00FF);
        reg_wr(3'd3, 16'h00FF); cyc(1);
        check("R6", "all lines low after clears", 32'(irq), 32'h0);
    endtask

    task automatic t_mid_reset();
        logic [15:0] d;
        evt[5] = 1'b1; cyc(1); evt = '0;
        cyc(1);
        check("R5", "pending before reset", 32'(irq), 32'h2);
        rst_n = 1'b0; cyc(1); rst_n = 1'b1;
        check("R1", "irq cleared by reset", 32'(irq), 32'h0);
        reg_rd(3'd0, d);
        check("R1", "status cleared by reset", 32'(d), 32'h0);
        reg_rd(3'd4, d);
        check("R1", "route restored by reset", 32'(d), 32'hFFFF);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_sticky();
        t_route();
        t_w1c();
        t_shared();
        t_race();
        t_no_priority();
        t_mid_reset();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule